// File: doc/BRIEF.md
# Dual-Rail Four-Phase Word Link

This block moves a W-bit word between two points over 2W wires. No separate strobe travels with the data. Every bit travels on its own pair of wires, a zero-rail and a one-rail. Both wires low means no data (the spacer). A single raised wire names the bit value. The sending side accepts a word through a valid/ready handshake and raises one rail of every pair. It then waits for the acknowledge from the far side and returns every pair to the spacer. Each word therefore has four phases: data out, acknowledge up, spacer out, acknowledge down.

The receiving side registers the rails on every clock. A completion detector decides that a word has arrived only when every pair holds a legal code. The receiver then presents the decoded word for one cycle and raises its acknowledge. It holds the acknowledge until every pair is back at the spacer, so a pair that lags behind can never be mistaken for part of the next word. A pair with both wires high is illegal and is reported on an error output.

The two halves share one top so that the rails and the acknowledge can be routed between chip regions, or looped straight back.

Top module: `drlink_top`

## Requirements
- R1: On accepting word d, the sender drives tx_one = d and tx_zero = ~d on the next clock edge. Bit i uses pair i, and the spacer (both rails low) is the idle level.
- R2: tx_ready is high only while the sender is idle and ack_in is low. A word is accepted on a clock edge where tx_valid and tx_ready are both high.
- R3: The sender holds its data rails unchanged while ack_in is low. On the first edge that finds ack_in high, it drives every pair to the spacer.
- R4: After the spacer phase, the sender raises tx_ready only after ack_in has returned low. tx_ready stays low while ack_in stays high.
- R5: The receiver does not acknowledge while any pair is still at the spacer, even when the other pairs hold legal codes.
- R6: Two edges after the receive rails first show a legal code on every pair, ack_out rises. At the same time rx_data shows the rail-one values, and rx_valid is high for exactly that one cycle.
- R7: ack_out falls two edges after every receive pair is at the spacer. It stays high while any pair still holds a code.
- R8: A pair with both rails high never counts as a legal code. rx_err is high two edges after such a pair appears on the receive rails, and it clears two edges after the pair goes away.
- R9: The sender never drives both rails of a pair high.
- R10: With the rails and the acknowledge looped back, the words on rx_data appear in the same order and with the same values as the words accepted on tx_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_data | input | W | Word to send |
| tx_valid | input | 1 | tx_data is offered |
| tx_ready | output | 1 | Sender can accept a word |
| tx_one | output | W | Sender rail-one wires |
| tx_zero | output | W | Sender rail-zero wires |
| ack_in | input | 1 | Acknowledge from the receiving side |
| rx_one | input | W | Receiver rail-one wires |
| rx_zero | input | W | Receiver rail-zero wires |
| ack_out | output | 1 | Receiver acknowledge |
| rx_data | output | W | Last decoded word |
| rx_valid | output | 1 | One-cycle pulse when rx_data is new |
| rx_err | output | 1 | A pair shows both rails high |

## Verification
The sender's rails change one edge after the accepting edge or the acknowledge edge. Its ready output follows its state and ack_in with no extra register. The receiver adds a rail sampling register in front of its decision register, so ack_out, rx_data, rx_valid and rx_err answer two edges after the rails change. The bench drives inputs and samples outputs on falling edges, and checks each result on the exact falling edge where it is due: one, or two, edges after the change. In the looped test the bench does not count cycles. It queues the accepted words and compares each rx_valid pulse against the head of the queue.

// File: rtl/drlink_pkg.sv
package drlink_pkg;
  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_DATA  = 2'd1,
    TX_SPACE = 2'd2
  } tx_state_e;
endpackage

// File: rtl/drlink_cdet.sv
module drlink_cdet #(
  parameter int W = 8
) (
  input  logic [W-1:0] one_r,
  input  logic [W-1:0] zero_r,
  output logic         all_code,
  output logic         all_space,
  output logic         any_bad
);
  logic [W-1:0] code_b, space_b, bad_b;

  for (genvar i = 0; i < W; i++) begin : g_pair
    assign code_b[i]  = one_r[i] ^ zero_r[i];
    assign space_b[i] = ~(one_r[i] | zero_r[i]);
    assign bad_b[i]   = one_r[i] & zero_r[i];
  end

  assign all_code  = &code_b;
  assign all_space = &space_b;
  assign any_bad   = |bad_b;
endmodule

// File: rtl/drlink_tx.sv
module drlink_tx
  import drlink_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] tx_data,
  input  logic         tx_valid,
  output logic         tx_ready,
  output logic [W-1:0] tx_one,
  output logic [W-1:0] tx_zero,
  input  logic         ack_in
);
  tx_state_e st;

  assign tx_ready = (st == TX_IDLE) && !ack_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= TX_IDLE;
      tx_one  <= '0;
      tx_zero <= '0;
    end else begin
      unique case (st)
        TX_IDLE: if (tx_valid && tx_ready) begin
          tx_one  <= tx_data;
          tx_zero <= ~tx_data;
          st      <= TX_DATA;
        end
        TX_DATA: if (ack_in) begin
          tx_one  <= '0;
          tx_zero <= '0;
          st      <= TX_SPACE;
        end
        TX_SPACE: if (!ack_in) st <= TX_IDLE;
        default: st <= TX_IDLE;
      endcase
    end
  end

  // R9
  rails_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_one & tx_zero) == '0);

  // R3
  hold_rails_chk: assert property (@(posedge clk) disable iff (rst)
    ((|tx_one) || (|tx_zero)) && !ack_in |=> $stable(tx_one) && $stable(tx_zero));

  // R2
  ready_gate_chk: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> !ack_in);
endmodule

// File: rtl/drlink_rx.sv
module drlink_rx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] rx_one,
  input  logic [W-1:0] rx_zero,
  output logic         ack_out,
  output logic [W-1:0] rx_data,
  output logic         rx_valid,
  output logic         rx_err
);
  logic [W-1:0] s_one, s_zero;
  logic         all_code, all_space, any_bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_one  <= '0;
      s_zero <= '0;
    end else begin
      s_one  <= rx_one;
      s_zero <= rx_zero;
    end
  end

  drlink_cdet #(.W(W)) u_cdet (
    .one_r    (s_one),
    .zero_r   (s_zero),
    .all_code (all_code),
    .all_space(all_space),
    .any_bad  (any_bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_out  <= 1'b0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      rx_err   <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      rx_err   <= any_bad;
      if (!ack_out && all_code) begin
        ack_out  <= 1'b1;
        rx_data  <= s_one;
        rx_valid <= 1'b1;
      end else if (ack_out && all_space) begin
        ack_out <= 1'b0;
      end
    end
  end

  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R6
  ack_with_data_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_out) |-> rx_valid);

  // R7
  ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_out) |-> $past(all_space));
endmodule

// File: rtl/drlink_top.sv
module drlink_top #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] tx_data,
  input  logic         tx_valid,
  output logic         tx_ready,
  output logic [W-1:0] tx_one,
  output logic [W-1:0] tx_zero,
  input  logic         ack_in,
  input  logic [W-1:0] rx_one,
  input  logic [W-1:0] rx_zero,
  output logic         ack_out,
  output logic [W-1:0] rx_data,
  output logic         rx_valid,
  output logic         rx_err
);
  drlink_tx #(.W(W)) u_tx (
    .clk     (clk),
    .rst     (rst),
    .tx_data (tx_data),
    .tx_valid(tx_valid),
    .tx_ready(tx_ready),
    .tx_one  (tx_one),
    .tx_zero (tx_zero),
    .ack_in  (ack_in)
  );

  drlink_rx #(.W(W)) u_rx (
    .clk     (clk),
    .rst     (rst),
    .rx_one  (rx_one),
    .rx_zero (rx_zero),
    .ack_out (ack_out),
    .rx_data (rx_data),
    .rx_valid(rx_valid),
    .rx_err  (rx_err)
  );
endmodule

// File: tb/drlink_top_bench.sv
module drlink_top_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] tx_data = '0;
  logic         tx_valid = 1'b0;
  logic         tx_ready;
  logic [W-1:0] tx_one, tx_zero;
  logic         ack_in;
  logic [W-1:0] rx_one, rx_zero;
  logic         ack_out;
  logic [W-1:0] rx_data;
  logic         rx_valid;
  logic         rx_err;

  logic         loop_en = 1'b0;
  logic         ack_force_en = 1'b1;
  logic         ack_force = 1'b0;
  logic [W-1:0] drv_one = '0, drv_zero = '0;

  assign rx_one  = loop_en ? tx_one  : drv_one;
  assign rx_zero = loop_en ? tx_zero : drv_zero;
  assign ack_in  = ack_force_en ? ack_force : ack_out;

  int checks = 0, fails = 0, bad_rail_cycles = 0, rcv_count = 0, sent_count = 0;
  logic [W-1:0] expq[$];

  always #2 clk = ~clk;

  drlink_top #(.W(W)) u_drlink_top (
    .clk(clk), .rst(rst),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_one(tx_one), .tx_zero(tx_zero), .ack_in(ack_in),
    .rx_one(rx_one), .rx_zero(rx_zero), .ack_out(ack_out),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_err(rx_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] enc_one(input logic [W-1:0] d);
    return d;
  endfunction
  function automatic logic [W-1:0] enc_zero(input logic [W-1:0] d);
    return ~d;
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // watchdog, R9 rail monitor, R10 scoreboard
  int cyc = 0;
  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      finish_run();
    end
    if (!rst && ((tx_one & tx_zero) != '0)) bad_rail_cycles++;
    if (!rst && loop_en && rx_valid) begin
      rcv_count++;
      if (expq.size() == 0) chk("R10 unexpected word", {24'd0, rx_data}, 32'hFFFF_FFFF);
      else chk("R10 word", {24'd0, rx_data}, {24'd0, expq.pop_front()});
    end
  end

  task automatic send(input logic [W-1:0] d);
    tx_data  = d;
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    expq.push_back(d);
    sent_count++;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset one-rails", {24'd0, tx_one}, 32'd0);
    chk("R1 reset zero-rails", {24'd0, tx_zero}, 32'd0);
    chk("R2 reset ready", {31'd0, tx_ready}, 32'd1);
    chk("R6 reset ack", {31'd0, ack_out}, 32'd0);
    chk("R8 reset err", {31'd0, rx_err}, 32'd0);

    // Sender alone, acknowledge driven by bench
    tx_data = 8'hA5; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    chk("R1 one-rails", {24'd0, tx_one}, {24'd0, enc_one(8'hA5)});
    chk("R1 zero-rails", {24'd0, tx_zero}, {24'd0, enc_zero(8'hA5)});
    chk("R2 ready low while busy", {31'd0, tx_ready}, 32'd0);
    repeat (4) @(negedge clk);
    chk("R3 rails held", {24'd0, tx_one}, 32'hA5);
    ack_force = 1'b1;
    @(negedge clk);
    chk("R3 spacer one", {24'd0, tx_one}, 32'd0);
    chk("R3 spacer zero", {24'd0, tx_zero}, 32'd0);
    repeat (4) @(negedge clk);
    chk("R4 ready waits for ack low", {31'd0, tx_ready}, 32'd0);
    ack_force = 1'b0;
    @(negedge clk);
    chk("R4 ready after ack low", {31'd0, tx_ready}, 32'd1);
    chk("R2 no accept while valid low", {24'd0, tx_one}, 32'd0);

    // Receiver alone, rails driven by bench
    drv_one = 8'h0C; drv_zero = 8'h03;
    repeat (3) @(negedge clk);
    chk("R5 partial word no ack", {31'd0, ack_out}, 32'd0);
    drv_one = 8'h3C; drv_zero = 8'hC3;
    @(negedge clk);
    chk("R6 ack not yet", {31'd0, ack_out}, 32'd0);
    @(negedge clk);
    chk("R6 ack up", {31'd0, ack_out}, 32'd1);
    chk("R6 valid pulse", {31'd0, rx_valid}, 32'd1);
    chk("R6 data", {24'd0, rx_data}, 32'h3C);
    @(negedge clk);
    chk("R6 pulse one cycle", {31'd0, rx_valid}, 32'd0);
    drv_one = 8'h30; drv_zero = 8'h00;
    repeat (3) @(negedge clk);
    chk("R7 ack held on partial spacer", {31'd0, ack_out}, 32'd1);
    drv_one = 8'h00;
    @(negedge clk);
    chk("R7 ack not yet down", {31'd0, ack_out}, 32'd1);
    @(negedge clk);
    chk("R7 ack down", {31'd0, ack_out}, 32'd0);
    drv_one = 8'hFF; drv_zero = 8'h01;
    @(negedge clk);
    @(negedge clk);
    chk("R8 err up", {31'd0, rx_err}, 32'd1);
    chk("R8 illegal pair not complete", {31'd0, ack_out}, 32'd0);
    drv_one = 8'h00; drv_zero = 8'h00;
    @(negedge clk);
    @(negedge clk);
    chk("R8 err clears", {31'd0, rx_err}, 32'd0);

    // Looped link
    ack_force_en = 1'b0;
    loop_en = 1'b1;
    @(negedge clk);
    send(8'h00);
    send(8'hFF);
    for (int k = 0; k < 40; k++) begin
      send(W'($urandom));
      if ($urandom_range(0, 3) == 0) repeat ($urandom_range(1, 5)) @(negedge clk);
    end
    repeat (20) @(negedge clk);
    chk("R10 all words delivered", rcv_count, sent_count);
    chk("R9 no pair both high", bad_rail_cycles, 0);
    finish_run();
  end
endmodule